// File: doc/BRIEF.md
# Acquisition Message Formatter

This block turns acquisition events into 64-bit typed messages and feeds them to the write port of a downstream buffer FIFO. A trigger request carries a 48-bit timestamp and becomes one trigger message. A decimated sample strobe carries four 24-bit lanes. In two-lane mode it becomes one sample message for lanes 1 and 2. In four-lane mode it becomes two messages, for lanes 1 and 2 and then for lanes 3 and 4. Each sample message carries tags that name its two lanes.

The downstream FIFO only reports that it is full. Messages therefore pass through a small staging queue of `QDEPTH` entries. While the downstream side is full, the message at the head of the queue waits. When the queue itself has no room left, new messages are thrown away. At the first cycle with room again, one overflow marker is queued. It sits after the older messages that were kept and before anything newer, so readers see exactly where the data stream has a gap.

Top module: `acq_msg_formatter`

## Requirements
- R1: A sample message holds 0x10 in bits 63:56, the higher lane's tag in 55:52, the lower lane's tag in 51:48, the higher lane's sample in 47:24 and the lower lane's sample in 23:0. Lane k (k = 1..4) is taken from `smp_lanes[24k-1:24k-24]` and has tag k-1.
- R2: When `quad_mode` is 0, each `smp_valid` pulse yields exactly one sample message, for lanes 1 and 2.
- R3: When `quad_mode` is 1, each `smp_valid` pulse yields two sample messages: lanes 1 and 2 first, then lanes 3 and 4.
- R4: A trigger message holds 0x11 in bits 63:56, zero in 55:48 and the timestamp in 47:0.
- R5: If a trigger request and a sample strobe arrive in the same cycle, the trigger message is written before the sample messages.
- R6: At most one message is written per cycle, and messages are written in arrival order. `fifo_wr` is never high while `fifo_full` is high, and the pending head message stays unchanged until it is written.
- R7: The staging queue holds up to `QDEPTH` messages. A message that arrives when the queue has no room is discarded and is never written.
- R8: After any discard, exactly one overflow message is written. It holds 0x40 in bits 63:56 and zero in 55:0. It follows every kept older message and comes before every newer message.
- R9: After reset, no message is written until an event arrives, and no overflow marker is pending.
- R10: If the downstream side stalls but nothing is discarded, no overflow message is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_req | input | 1 | Trigger event this cycle |
| trig_time | input | 48 | Timestamp of the trigger event |
| smp_valid | input | 1 | Decimated sample available this cycle |
| smp_lanes | input | 96 | Four 24-bit lane samples; lane 1 in the lowest bits |
| quad_mode | input | 1 | 1 selects four-lane mode, 0 selects two-lane mode |
| fifo_full | input | 1 | Downstream FIFO cannot accept a write |
| fifo_wr | output | 1 | Write strobe to the downstream FIFO |
| fifo_wdata | output | 64 | Message to write |

## Verification
The bench drives single cycles that hold a trigger alone, a sample alone in each mode, a trigger together with a sample in each mode, and no event at all. These cases separate wrong packing, missing second messages and wrong order within a cycle. Two stall runs follow. In the first, the downstream side is held full while more samples arrive than the queue can hold; this checks that the dropped data never shows up and that exactly one marker appears between the kept data and a later sample. In the second, the stall is released just before any drop, which checks that a stall without loss adds no marker.

// File: rtl/acq_fmt_pkg.sv
package acq_fmt_pkg;
    localparam int MSG_W   = 64;
    localparam int TS_W    = 48;
    localparam int SMP_W   = 24;
    localparam int NLANE   = 4;
    localparam int NPAIR   = NLANE / 2;
    localparam int NCAND   = 1 + NPAIR;

    localparam logic [7:0] KIND_SAMPLE  = 8'h10;
    localparam logic [7:0] KIND_TRIGGER = 8'h11;
    localparam logic [7:0] KIND_LOSS    = 8'h40;

    localparam logic [MSG_W-1:0] LOSS_MSG = {KIND_LOSS, 56'h0};

    function automatic logic [MSG_W-1:0] make_trigger(input logic [TS_W-1:0] ts);
        return {KIND_TRIGGER, 8'h00, ts};
    endfunction

    function automatic logic [MSG_W-1:0] make_sample(input logic [3:0] tag_hi,
                                                     input logic [3:0] tag_lo,
                                                     input logic [SMP_W-1:0] s_hi,
                                                     input logic [SMP_W-1:0] s_lo);
        return {KIND_SAMPLE, tag_hi, tag_lo, s_hi, s_lo};
    endfunction
endpackage

// File: rtl/acq_fmt_pack.sv
module acq_fmt_pack
    import acq_fmt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig_req,
    input  logic [TS_W-1:0]          trig_time,
    input  logic                     smp_valid,
    input  logic [NLANE*SMP_W-1:0]   smp_lanes,
    input  logic                     quad_mode,
    output logic [NCAND-1:0]         cand_vld,
    output logic [NCAND-1:0][MSG_W-1:0] cand_msg
);
    // candidate 0 is the trigger: it is always offered ahead of samples
    assign cand_vld[0] = trig_req;
    assign cand_msg[0] = make_trigger(trig_time);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam logic [3:0] TAG_LO = 4'(2 * p);
        localparam logic [3:0] TAG_HI = 4'(2 * p + 1);
        assign cand_msg[p+1] = make_sample(TAG_HI, TAG_LO,
                                           smp_lanes[(2*p+1)*SMP_W +: SMP_W],
                                           smp_lanes[(2*p)*SMP_W +: SMP_W]);
        if (p == 0) begin : g_base
            assign cand_vld[p+1] = smp_valid;
        end else begin : g_ext
            assign cand_vld[p+1] = smp_valid && quad_mode;
        end
    end

    AST_SECOND_PAIR_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        cand_vld[2] |-> (cand_vld[1] && quad_mode)); // R3
endmodule

// File: rtl/acq_fmt_queue.sv
module acq_fmt_queue
    import acq_fmt_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCAND-1:0]            cand_vld,
    input  logic [NCAND-1:0][MSG_W-1:0] cand_msg,
    input  logic                        fifo_full,
    output logic                        fifo_wr,
    output logic [MSG_W-1:0]            fifo_wdata
);
    localparam int CW = $clog2(QDEPTH + 1);
    localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(QDEPTH);

    typedef struct packed {
        logic [QDEPTH-1:0][MSG_W-1:0] mem;
        logic [CW-1:0]                cnt;
        logic                         lost;
    } qstate_t;

    qstate_t st_d, st_q;
    logic    pop;

    always_comb begin
        st_d = st_q;
        pop  = (st_q.cnt != '0) && !fifo_full;
        if (pop) begin
            for (int i = 0; i < QDEPTH - 1; i++) begin
                st_d.mem[i] = st_q.mem[i+1];
            end
            st_d.mem[QDEPTH-1] = '0;
            st_d.cnt = st_q.cnt - 1'b1;
        end
        // a pending loss marker takes the first free slot, before new data
        if (st_d.lost && (st_d.cnt < FULL_CNT)) begin
            st_d.mem[st_d.cnt[IW-1:0]] = LOSS_MSG;
            st_d.cnt  = st_d.cnt + 1'b1;
            st_d.lost = 1'b0;
        end
        for (int k = 0; k < NCAND; k++) begin
            if (cand_vld[k]) begin
                if (st_d.cnt < FULL_CNT) begin
                    st_d.mem[st_d.cnt[IW-1:0]] = cand_msg[k];
                    st_d.cnt = st_d.cnt + 1'b1;
                end else begin
                    st_d.lost = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_wr    = pop;
    assign fifo_wdata = st_q.mem[0];

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && st_q.cnt != '0) |=> $stable(fifo_wdata)); // R6
    AST_LOSS_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lost |-> (st_q.cnt == FULL_CNT)); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R7
    AST_LOSS_MSG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_wdata[63:56] == KIND_LOSS) |-> (fifo_wdata[55:0] == '0)); // R8
endmodule

// File: rtl/acq_msg_formatter.sv
module acq_msg_formatter
    import acq_fmt_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_req,
    input  logic [47:0] trig_time,
    input  logic        smp_valid,
    input  logic [95:0] smp_lanes,
    input  logic        quad_mode,
    input  logic        fifo_full,
    output logic        fifo_wr,
    output logic [63:0] fifo_wdata
);
    logic [NCAND-1:0]            cand_vld;
    logic [NCAND-1:0][MSG_W-1:0] cand_msg;

    acq_fmt_pack i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_req  (trig_req),
        .trig_time (trig_time),
        .smp_valid (smp_valid),
        .smp_lanes (smp_lanes),
        .quad_mode (quad_mode),
        .cand_vld  (cand_vld),
        .cand_msg  (cand_msg)
    );

    acq_fmt_queue #(.QDEPTH(QDEPTH)) i_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_vld   (cand_vld),
        .cand_msg   (cand_msg),
        .fifo_full  (fifo_full),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata)
    );

    AST_NO_WRITE_INTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr); // R6
    AST_KNOWN_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_wdata[63:56] == KIND_SAMPLE || fifo_wdata[63:56] == KIND_TRIGGER
                     || fifo_wdata[63:56] == KIND_LOSS)); // R1
    AST_TRIGGER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_wdata[63:56] == KIND_TRIGGER) |-> (fifo_wdata[55:48] == 8'h00)); // R4
endmodule

// File: tb/test_acq_msg_formatter.sv
`timescale 1ns/1ps
module test_acq_msg_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_req = 1'b0;
    logic [47:0] trig_time = '0;
    logic        smp_valid = 1'b0;
    logic [95:0] smp_lanes = '0;
    logic        quad_mode = 1'b0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [63:0] fifo_wdata;

    always #2.5 clk = ~clk;

    acq_msg_formatter i_acq_msg_formatter (.*);

    typedef struct packed {
        logic        trig;
        logic [47:0] ts;
        logic        sv;
        logic        quad;
        logic [23:0] s0, s1, s2, s3;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 48'h0123_4567_89AB, 1'b0, 1'b0, 24'h0, 24'h0, 24'h0, 24'h0},
        '{1'b0, 48'h0, 1'b1, 1'b0, 24'h111111, 24'h222222, 24'h333333, 24'h444444},
        '{1'b0, 48'h0, 1'b1, 1'b1, 24'hA00001, 24'hB00002, 24'hC00003, 24'hD00004},
        '{1'b1, 48'hFFFF_0000_0001, 1'b1, 1'b0, 24'h00000F, 24'hF00000, 24'h555555, 24'hAAAAAA},
        '{1'b1, 48'h8000_0000_0000, 1'b1, 1'b1, 24'hFFFFFF, 24'h000001, 24'h123456, 24'h654321},
        '{1'b0, 48'h0, 1'b0, 1'b1, 24'h777777, 24'h888888, 24'h999999, 24'hABCDEF}
    };

    int nchk = 0;
    int nfail = 0;
    logic [63:0] cap [32];
    int ncap = 0;
    logic [63:0] expq [32];
    int nexp = 0;

    function automatic logic [63:0] smp_msg(logic [3:0] th, logic [3:0] tl, logic [23:0] sh, logic [23:0] sl);
        return {8'h10, th, tl, sh, sl};
    endfunction
    function automatic logic [63:0] trg_msg(logic [47:0] ts);
        return {8'h11, 8'h00, ts};
    endfunction
    localparam logic [63:0] LOSS = {8'h40, 56'h0};

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (fifo_wr && ncap < 32) begin
            cap[ncap] = fifo_wdata;
            ncap++;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        trig_req = 1'b0;
        smp_valid = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic compare(input string req);
        check(ncap == nexp, req, 64'(ncap), 64'(nexp));
        for (int i = 0; i < nexp; i++) begin
            if (i < ncap) check(cap[i] == expq[i], req, cap[i], expq[i]);
        end
        ncap = 0;
        nexp = 0;
    endtask

    task automatic push_exp(input logic [63:0] m);
        expq[nexp] = m;
        nexp++;
    endtask

    task automatic send_pair(input logic [23:0] a, input logic [23:0] b);
        smp_valid = 1'b1;
        quad_mode = 1'b0;
        smp_lanes = {48'h0, b, a};
        tick();
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check(fifo_wr == 1'b0, "R9 in reset", 64'(fifo_wr), 64'd0);
        rst_n = 1'b1;
        idle(4);
        check(ncap == 0, "R9 idle after reset", 64'(ncap), 64'd0);
        ncap = 0;

        // table of single-cycle events: R1 R2 R3 R4 R5
        foreach (VECS[v]) begin
            trig_req  = VECS[v].trig;
            trig_time = VECS[v].ts;
            smp_valid = VECS[v].sv;
            quad_mode = VECS[v].quad;
            smp_lanes = {VECS[v].s3, VECS[v].s2, VECS[v].s1, VECS[v].s0};
            if (VECS[v].trig) push_exp(trg_msg(VECS[v].ts));
            if (VECS[v].sv) push_exp(smp_msg(4'h1, 4'h0, VECS[v].s1, VECS[v].s0));
            if (VECS[v].sv && VECS[v].quad) push_exp(smp_msg(4'h3, 4'h2, VECS[v].s3, VECS[v].s2));
            tick();
            idle(6);
            compare("R1 R2 R3 R4 R5 vector");
        end

        // R7 R8 R6: stall with loss
        fifo_full = 1'b1;
        for (int i = 0; i < 6; i++) send_pair(24'h100 + 24'(i), 24'h200 + 24'(i));
        idle(3);
        check(ncap == 0, "R6 no write while full", 64'(ncap), 64'd0);
        fifo_full = 1'b0;
        idle(8);
        for (int i = 0; i < 4; i++) push_exp(smp_msg(4'h1, 4'h0, 24'h200 + 24'(i), 24'h100 + 24'(i)));
        push_exp(LOSS);
        send_pair(24'h0ABCDE, 24'h0FEDCB);
        push_exp(smp_msg(4'h1, 4'h0, 24'h0FEDCB, 24'h0ABCDE));
        idle(4);
        compare("R7 R8 loss marker placement");

        // R10: stall without loss
        fifo_full = 1'b1;
        for (int i = 0; i < 4; i++) send_pair(24'h300 + 24'(i), 24'h400 + 24'(i));
        idle(2);
        fifo_full = 1'b0;
        idle(8);
        for (int i = 0; i < 4; i++) push_exp(smp_msg(4'h1, 4'h0, 24'h400 + 24'(i), 24'h300 + 24'(i)));
        compare("R10 stall without loss");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule